// File: doc/BRIEF.md
# Overriding Two-Level Branch Direction Predictor

This block predicts whether a conditional branch is taken, using two predictors of different speed that look up the same fetch address in parallel. The fast level is a small, untagged table of 2-bit saturating counters. Its index is the fetch PC hashed with global history, and it answers combinationally in the lookup cycle, so fetch can steer on it straight away. The slow level is a larger, set-associative table with tags. Its index folds in the whole global history, which is longer than the part the fast level uses. Its result arrives a fixed two cycles later, together with the identifier of the request it answers.

When the slow level finds a matching entry and its direction disagrees with the fast answer, it raises a one-cycle override. Fetch then redirects. When the slow level has no matching entry, it repeats the fast answer and stays silent. The slow level is not a cache of the fast one. It only holds branches that the fast table got wrong before, so its area goes to hard branches.

Branch outcomes come back through a resolve port. Each outcome trains both levels, shifts the global history, and on a fast-level miss that went unhandled it allocates a slow-level entry. A flush input cancels every lookup still in the slow pipeline.

Top module: `ovr_bpred`

## Requirements
- R1: `early_valid` equals `req_valid` in the same cycle. `early_taken` is bit 1 of the fast counter at index `req_pc[7:2] ^ ghr[5:0]`. After reset every fast counter holds 2'b01 (weakly not taken).
- R2: A request accepted in cycle t gives `late_valid` high in cycle t+2, that is, after the second rising edge. `late_id` then equals the `req_id` of that request. No other cycle shows `late_valid` for it.
- R3: The slow level has 16 sets of 2 ways. The set is `pc[5:2] ^ ghr[3:0] ^ ghr[7:4]` and the tag is `pc[11:6]`. On a tag hit, `late_taken` is bit 1 of that entry's counter. On a miss, `late_taken` repeats the request's `early_taken`.
- R4: `override` is high only together with `late_valid`, only for a tag hit, and only when `late_taken` differs from the request's `early_taken`. It lasts that single cycle.
- R5: A resolve (`upd_valid`) steps the fast counter at the update index up on taken or down on not taken, saturating at 0 and 3. A slow-level entry that hits is stepped the same way. The 8-bit history `ghr` then shifts left with the outcome in bit 0. The indices are computed from the history before this shift.
- R6: A slow-level entry is allocated only when the resolve misses in the slow level and the fast counter's bit 1 differs from the outcome. The new entry's counter is 2'b10 for taken and 2'b01 for not taken. A resolve that the fast level predicted correctly allocates nothing.
- R7: The allocation victim is an invalid way if one exists, with way 0 before way 1. Otherwise it is the way whose counter is weak (2'b01 or 2'b10) rather than strong (2'b00 or 2'b11). When both ways are weak or both are strong, way 0 is replaced.
- R8: While `flush` is high, the request presented in that cycle and both lookups in flight are dropped. None of them later shows `late_valid` or `override`. Requests after the flush proceed normally.
- R9: After reset the history is zero, the slow level is empty, and `late_valid` and `override` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Cancels the slow lookups in flight and the request in this cycle |
| req_valid | input | 1 | Lookup request |
| req_pc | input | PC_W | Fetch address of the branch |
| req_id | input | ID_W | Request identifier carried to the late result |
| upd_valid | input | 1 | Resolve strobe |
| upd_pc | input | PC_W | Address of the resolved branch |
| upd_taken | input | 1 | Resolved direction |
| early_valid | output | 1 | Fast prediction is valid |
| early_taken | output | 1 | Fast predicted direction |
| late_valid | output | 1 | Slow result is valid |
| late_id | output | ID_W | Identifier of the request that the slow result answers |
| late_taken | output | 1 | Slow (final) predicted direction |
| override | output | 1 | The slow result contradicts the fast one |

## Verification
The main sequence uses two branches that alias in the fast table but carry different slow-level tags. One is trained taken and the other not taken, so the fast counter flips while the slow entry holds. This separates a correct override from a wrong fallback and from a missing tag compare. A filler branch, always not taken, walks the history back to zero without touching the shared fast counter. A third aliasing branch then forces an eviction in a full set. The expected result distinguishes replacing the weak entry from replacing the strong one. Back-to-back requests with distinct identifiers test that each late result is paired with its own request. Flushes at two pipeline depths test that both in-flight lookups are dropped.

// File: rtl/ovr_bpred.sv
module ovr_bpred #(
  parameter int PC_W   = 16,
  parameter int L1_W   = 6,
  parameter int HIST_W = 8,
  parameter int SET_W  = 4,
  parameter int TAG_W  = 6,
  parameter int ID_W   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            req_valid,
  input  logic [PC_W-1:0] req_pc,
  input  logic [ID_W-1:0] req_id,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  output logic            early_valid,
  output logic            early_taken,
  output logic            late_valid,
  output logic [ID_W-1:0] late_id,
  output logic            late_taken,
  output logic            override
);
  localparam int L1_N  = 1 << L1_W;
  localparam int SETS  = 1 << SET_W;
  localparam int FOLDS = HIST_W / SET_W;

  function automatic logic [L1_W-1:0] l1_hash(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h);
    return pc[L1_W+1:2] ^ h[L1_W-1:0];
  endfunction

  function automatic logic [SET_W-1:0] set_hash(input logic [PC_W-1:0] pc, input logic [HIST_W-1:0] h);
    logic [SET_W-1:0] r;
    r = pc[SET_W+1:2];
    for (int i = 0; i < FOLDS; i++) r = r ^ h[i*SET_W +: SET_W];
    return r;
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [PC_W-1:0] pc);
    return pc[SET_W+TAG_W+1:SET_W+2];
  endfunction

  function automatic logic [1:0] step(input logic [1:0] c, input logic t);
    if (t) return (c == 2'b11) ? c : c + 2'b01;
    return (c == 2'b00) ? c : c - 2'b01;
  endfunction

  function automatic logic is_weak(input logic [1:0] c);
    return c[1] ^ c[0];
  endfunction

  logic [1:0]        l1_ctr [L1_N];
  logic [HIST_W-1:0] ghr;
  logic [1:0]        l2_v   [SETS];
  logic [TAG_W-1:0]  l2_tag [SETS][2];
  logic [1:0]        l2_ctr [SETS][2];

  // fast level
  logic [L1_W-1:0] q_idx;
  assign q_idx       = l1_hash(req_pc, ghr);
  assign early_valid = req_valid;
  assign early_taken = l1_ctr[q_idx][1];

  // slow level, stage 1
  logic             s1_v, s1_early;
  logic [ID_W-1:0]  s1_id;
  logic [SET_W-1:0] s1_set;
  logic [TAG_W-1:0] s1_tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v <= 1'b0;
      s1_early <= 1'b0;
      s1_id <= '0;
      s1_set <= '0;
      s1_tag <= '0;
    end else begin
      s1_v <= req_valid & ~flush;
      s1_early <= early_taken;
      s1_id <= req_id;
      s1_set <= set_hash(req_pc, ghr);
      s1_tag <= tag_of(req_pc);
    end
  end

  // slow level, stage 2
  logic       rd_hit;
  logic [1:0] rd_ctr;
  always_comb begin
    rd_hit = 1'b0;
    rd_ctr = 2'b00;
    for (int w = 0; w < 2; w++)
      if (l2_v[s1_set][w] && l2_tag[s1_set][w] == s1_tag) begin
        rd_hit = 1'b1;
        rd_ctr = l2_ctr[s1_set][w];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      late_valid <= 1'b0;
      late_id <= '0;
      late_taken <= 1'b0;
      override <= 1'b0;
    end else begin
      late_valid <= s1_v & ~flush;
      late_id <= s1_id;
      late_taken <= rd_hit ? rd_ctr[1] : s1_early;
      override <= s1_v & ~flush & rd_hit & (rd_ctr[1] ^ s1_early);
    end
  end

  // resolve
  logic [L1_W-1:0]  u_idx;
  logic [SET_W-1:0] u_set;
  logic [TAG_W-1:0] u_tag;
  logic             u_hit, u_way, u_vict, u_wrong;
  assign u_idx   = l1_hash(upd_pc, ghr);
  assign u_set   = set_hash(upd_pc, ghr);
  assign u_tag   = tag_of(upd_pc);
  assign u_wrong = l1_ctr[u_idx][1] ^ upd_taken;

  always_comb begin
    u_hit = 1'b0;
    u_way = 1'b0;
    for (int w = 0; w < 2; w++)
      if (l2_v[u_set][w] && l2_tag[u_set][w] == u_tag) begin
        u_hit = 1'b1;
        u_way = w[0];
      end
    if (!l2_v[u_set][0])                          u_vict = 1'b0;
    else if (!l2_v[u_set][1])                     u_vict = 1'b1;
    else if (is_weak(l2_ctr[u_set][0]))           u_vict = 1'b0;
    else if (is_weak(l2_ctr[u_set][1]))           u_vict = 1'b1;
    else                                          u_vict = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ghr <= '0;
      for (int i = 0; i < L1_N; i++) l1_ctr[i] <= 2'b01;
      for (int s = 0; s < SETS; s++) begin
        l2_v[s] <= 2'b00;
        for (int w = 0; w < 2; w++) begin
          l2_tag[s][w] <= '0;
          l2_ctr[s][w] <= 2'b01;
        end
      end
    end else if (upd_valid) begin
      l1_ctr[u_idx] <= step(l1_ctr[u_idx], upd_taken);
      ghr <= {ghr[HIST_W-2:0], upd_taken};
      if (u_hit)
        l2_ctr[u_set][u_way] <= step(l2_ctr[u_set][u_way], upd_taken);
      else if (u_wrong) begin
        l2_v[u_set][u_vict]   <= 1'b1;
        l2_tag[u_set][u_vict] <= u_tag;
        l2_ctr[u_set][u_vict] <= upd_taken ? 2'b10 : 2'b01;
      end
    end
  end
endmodule

// File: rtl/ovr_bpred_chk.sv
module ovr_bpred_chk #(
  parameter int ID_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic            req_valid,
  input logic [ID_W-1:0] req_id,
  input logic            early_taken,
  input logic            late_valid,
  input logic [ID_W-1:0] late_id,
  input logic            late_taken,
  input logic            override
);
  assert_ovr_with_late_R4: assert property (@(posedge clk) disable iff (!rst_n)
    override |-> late_valid);

  assert_ovr_differs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    override |-> (late_taken != $past(early_taken, 2)));

  assert_quiet_agrees_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (late_valid && !override) |-> (late_taken == $past(early_taken, 2)));

  assert_late_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    late_valid |-> $past(req_valid, 2));

  assert_late_id_R2: assert property (@(posedge clk) disable iff (!rst_n)
    late_valid |-> (late_id == $past(req_id, 2)));

  assert_flush_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(flush) |-> (!late_valid && !override));
endmodule

bind ovr_bpred ovr_bpred_chk #(.ID_W(ID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_id(req_id),
  .early_taken(early_taken), .late_valid(late_valid), .late_id(late_id),
  .late_taken(late_taken), .override(override)
);

// File: tb/sim_ovr_bpred.sv
module sim_ovr_bpred;
  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic req_valid = 1'b0, upd_valid = 1'b0, upd_taken = 1'b0;
  logic [15:0] req_pc = '0, upd_pc = '0;
  logic [3:0]  req_id = '0;
  logic early_valid, early_taken, late_valid, late_taken, override;
  logic [3:0] late_id;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  ovr_bpred u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .req_valid(req_valid), .req_pc(req_pc),
    .req_id(req_id), .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .early_valid(early_valid), .early_taken(early_taken), .late_valid(late_valid),
    .late_id(late_id), .late_taken(late_taken), .override(override)
  );

  // {pc, taken, expected early, expected late, expected override}
  // A=0100 and D=0200, E=0300 share fast index 0 and slow set 0; C=00FC walks history.
  localparam int NV = 22;
  localparam logic [19:0] VEC [NV] = '{
    {16'h0100, 4'b1000},                      // A taken: alloc R6
    {16'h00FC, 4'b0000}, {16'h00FC, 4'b0000}, {16'h00FC, 4'b0000}, {16'h00FC, 4'b0000},
    {16'h00FC, 4'b0000}, {16'h00FC, 4'b0000}, {16'h00FC, 4'b0000}, {16'h00FC, 4'b0000},
    {16'h0200, 4'b0110},                      // D: miss fallback R3, alloc way1 R7
    {16'h0100, 4'b1011},                      // A: hit disagrees, override R4
    {16'h00FC, 4'b0000}, {16'h00FC, 4'b0000}, {16'h00FC, 4'b0000}, {16'h00FC, 4'b0000},
    {16'h00FC, 4'b0000}, {16'h00FC, 4'b0000}, {16'h00FC, 4'b0000}, {16'h00FC, 4'b0000},
    {16'h0300, 4'b0110},                      // E: evicts weak D, keeps strong A R7
    {16'h0200, 4'b0000},                      // D now misses R7
    {16'h0100, 4'b1011}                       // A still hits R5 R7
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic predict(input logic [15:0] pc, input logic [3:0] id, input logic tk,
                         input logic e, input logic l, input logic o, input bit do_upd);
    @(negedge clk);
    req_valid = 1'b1; req_pc = pc; req_id = id;
    #1;
    chk("R1 early_valid", early_valid, 1);
    chk("R1 early_taken", early_taken, e);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R2 late_valid", late_valid, 1);
    chk("R2 late_id", late_id, id);
    chk("R3 late_taken", late_taken, l);
    chk("R4 override", override, o);
    if (do_upd) begin
      upd_valid = 1'b1; upd_pc = pc; upd_taken = tk;
    end
    @(negedge clk);
    upd_valid = 1'b0;
    chk("R4 override one cycle", override, 0);
    chk("R2 late_valid one cycle", late_valid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk("R9 late_valid after reset", late_valid, 0);
    chk("R9 override after reset", override, 0);
    predict(16'h1234, 4'd1, 1'b0, 1'b0, 1'b0, 1'b0, 0);
    predict(16'h0100, 4'd2, 1'b0, 1'b0, 1'b0, 1'b0, 0);

    // main sequence: R1 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++)
      predict(VEC[i][19:4], i[3:0], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], 1);

    // R2 back-to-back requests keep their ids
    @(negedge clk); req_valid = 1'b1; req_pc = 16'h0040; req_id = 4'd3;
    @(negedge clk); req_id = 4'd4;
    @(negedge clk); req_id = 4'd5;
    chk("R2 pipelined valid 3", late_valid, 1); chk("R2 pipelined id 3", late_id, 3);
    @(negedge clk); req_valid = 1'b0;
    chk("R2 pipelined valid 4", late_valid, 1); chk("R2 pipelined id 4", late_id, 4);
    @(negedge clk);
    chk("R2 pipelined valid 5", late_valid, 1); chk("R2 pipelined id 5", late_id, 5);
    @(negedge clk);
    chk("R2 pipeline drained", late_valid, 0);

    // R8 flush drops both stages and the concurrent request
    @(negedge clk); req_valid = 1'b1; req_pc = 16'h0100; req_id = 4'd7;
    @(negedge clk); flush = 1'b1; req_id = 4'd8;
    @(negedge clk); flush = 1'b0; req_id = 4'd9;
    chk("R8 in-flight dropped", late_valid, 0);
    chk("R8 no override for dropped", override, 0);
    @(negedge clk); req_valid = 1'b0;
    chk("R8 concurrent request dropped", late_valid, 0);
    @(negedge clk);
    chk("R8 resumes valid", late_valid, 1);
    chk("R8 resumes id", late_id, 9);
    @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end
endmodule